// File: doc/BRIEF.md
# Packet-Filter VM ALU Execute Unit

This block is the integer execute stage of a 64-bit register machine used to run packet-filter programs. The decoder gives it an operation class (32-bit or 64-bit), a 4-bit operation code, the 16-bit offset field, the destination register value, a source register value and the 32-bit immediate. The unit picks the second operand, runs add, subtract, the bitwise operations, the three shifts, move or move with sign extension, and registers the 64-bit result with a flag that marks an illegal encoding. Division, modulo and byte swapping are done by other execute blocks. When the encoding is illegal, this unit returns the destination value unchanged.

Results arrive one clock after the issue strobe, so the register file writes back in the cycle after issue. In the 32-bit class, every result has bits 63:32 cleared. Move with sign extension is the only operation here that gives the offset field a meaning, and the offset value selects the source width.

Top module: `pfvm_alu_exec`

## Requirements
- R1: `res_valid`, `result` and `illegal` update on the rising edge after `issue_valid` is sampled high. Synchronous reset (`rst_n` low) clears all three to 0. `illegal` is never 1 while `res_valid` is 0.
- R2: When `use_reg` is 1 the second operand is `src_reg`. When it is 0 the operand is `imm` sign-extended to 64 bits.
- R3: Op 0x0 (add) and op 0x1 (subtract, dst minus operand) wrap modulo 2^64 in the 64-bit class and modulo 2^32 in the 32-bit class.
- R4: Op 0x4 gives OR, op 0x5 gives AND and op 0xa gives XOR of the destination and the operand.
- R5: Op 0x6 shifts left and op 0x7 shifts right logically. The count is the operand ANDed with 0x3F in the 64-bit class and with 0x1F in the 32-bit class.
- R6: Op 0xc shifts right arithmetically and fills with bit 63 (64-bit class) or bit 31 (32-bit class) of the destination.
- R7: Op 0xb with offset 0 copies the operand to the result.
- R8: Op 0xb in the 64-bit class with offset 8, 16 or 32 sign-extends the low 8, 16 or 32 operand bits to 64 bits.
- R9: Op 0xb in the 32-bit class with offset 8 or 16 sign-extends the low 8 or 16 operand bits to 32 bits and clears bits 63:32. Offset 32 in the 32-bit class is illegal.
- R10: Every legal 32-bit-class result has bits 63:32 equal to 0. `is_64` is 1 for the 64-bit class.
- R11: A non-zero offset on any op other than 0xb, or an offset on op 0xb outside the legal set, sets `illegal` to 1 and returns `dst_val` as the result.
- R12: Op codes 0x2, 0x3, 0x8, 0x9, 0xd, 0xe and 0xf are not executed here. They set `illegal` to 1 and return `dst_val`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| issue_valid | input | 1 | An operation is presented this cycle |
| is_64 | input | 1 | 1 = 64-bit class, 0 = 32-bit class |
| op_code | input | 4 | Operation code (opcode bits 7:4) |
| use_reg | input | 1 | 1 = register operand, 0 = immediate (opcode bit 3) |
| offset | input | 16 | Instruction offset field |
| dst_val | input | 64 | Current destination register value |
| src_reg | input | 64 | Source register value |
| imm | input | 32 | Immediate field |
| res_valid | output | 1 | Result is valid |
| result | output | 64 | Value to write to the destination |
| illegal | output | 1 | Encoding is illegal; the result equals the old destination |

## Verification
On every cycle the assertions check the one-cycle issue-to-result timing and that the flag is only raised together with a valid result. They also check that a flagged result equals the sampled destination, that an accepted non-move operation had a zero offset, that a 32-bit-class result keeps its upper half clear, that a 32-bit-class 32-bit sign extension is rejected, and that an arithmetic right shift keeps the sign bit of its width. Only the bench scenarios can show the actual arithmetic values. These include wraparound, masking of the shift count, the value chosen for each extension width, and the sign extension of the immediate, because each needs a known operand paired with its computed answer.

// File: rtl/pfvm_alu_pkg.sv
// Package: shared constants and types for the packet-filter VM ALU.
// Assumes: op codes occupy opcode bits 7:4; their values are fixed by the ISA.
package pfvm_alu_pkg;

    // Operation codes handled by this execute unit
    localparam logic [3:0] OPC_ADD  = 4'h0;
    localparam logic [3:0] OPC_SUB  = 4'h1;
    localparam logic [3:0] OPC_OR   = 4'h4;
    localparam logic [3:0] OPC_AND  = 4'h5;
    localparam logic [3:0] OPC_LSH  = 4'h6;
    localparam logic [3:0] OPC_RSH  = 4'h7;
    localparam logic [3:0] OPC_XOR  = 4'ha;
    localparam logic [3:0] OPC_MOV  = 4'hb;
    localparam logic [3:0] OPC_ARSH = 4'hc;

    // Number of sign-extension source widths (8 << k, k = 0..N-1)
    localparam int EXT_TAPS = 3;

    // Shifter direction select
    typedef enum logic [1:0] {
        SHK_LEFT  = 2'd0,
        SHK_RIGHT = 2'd1,
        SHK_ARITH = 2'd2
    } shift_kind_e;

    // Which functional path produces the result
    typedef enum logic [1:0] {
        PATH_LOGIC = 2'd0,
        PATH_SHIFT = 2'd1,
        PATH_MOVE  = 2'd2,
        PATH_NONE  = 2'd3
    } exec_path_e;

    // Decoded control for one operation
    typedef struct packed {
        exec_path_e  path;
        shift_kind_e kind;
        logic        zero_off_needed;
    } exec_ctl_t;

    // Decode an op code into its path, shift kind and offset rule
    function automatic exec_ctl_t decode_op(input logic [3:0] opc);
        exec_ctl_t c;
        c.path            = PATH_NONE;
        c.kind            = SHK_LEFT;
        c.zero_off_needed = 1'b1;
        unique case (opc)
            OPC_ADD, OPC_SUB, OPC_OR, OPC_AND, OPC_XOR: c.path = PATH_LOGIC;
            OPC_LSH: begin c.path = PATH_SHIFT; c.kind = SHK_LEFT;  end
            OPC_RSH: begin c.path = PATH_SHIFT; c.kind = SHK_RIGHT; end
            OPC_ARSH: begin c.path = PATH_SHIFT; c.kind = SHK_ARITH; end
            OPC_MOV: begin c.path = PATH_MOVE; c.zero_off_needed = 1'b0; end
            default: c.path = PATH_NONE;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/pfvm_alu_operand.sv
// Module: second-operand selection.
// Does: returns the source register or the immediate sign-extended to XLEN.
// Assumes: IMMW <= XLEN.
module pfvm_alu_operand #(
    parameter int XLEN = 64,
    parameter int IMMW = 32
) (
    input  logic            use_reg,
    input  logic [XLEN-1:0] src_reg,
    input  logic [IMMW-1:0] imm,
    output logic [XLEN-1:0] operand
);
    logic [XLEN-1:0] imm_wide;

    // Sign-extend the immediate to the register width
    always_comb imm_wide = XLEN'($signed(imm));

    // Choose register or immediate operand
    always_comb operand = use_reg ? src_reg : imm_wide;

endmodule

// File: rtl/pfvm_alu_shift.sv
// Module: class-aware shifter.
// Does: left, logical right and arithmetic right shifts at full and half width.
//       Each lane masks the count to its own width, and the half lane returns
//       its result zero-extended.
// Assumes: XLEN is a power of two.
module pfvm_alu_shift
    import pfvm_alu_pkg::*;
#(
    parameter int XLEN = 64,
    localparam int SHW = $clog2(XLEN)
) (
    input  logic            is_full,
    input  shift_kind_e     kind,
    input  logic [XLEN-1:0] value,
    input  logic [SHW-1:0]  count,
    output logic [XLEN-1:0] shifted
);
    localparam int LANES = 2;

    logic [XLEN-1:0] lane_out [LANES];

    // Lane g works on XLEN >> g bits
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        localparam int W  = XLEN >> g;
        localparam int CW = $clog2(W);
        logic [W-1:0]  a;
        logic [CW-1:0] amt;
        logic [W-1:0]  r;

        // Slice the operand and mask the count to this lane's width
        always_comb begin
            a   = value[W-1:0];
            amt = count[CW-1:0];
        end

        // Shift in the direction asked for
        always_comb begin
            unique case (kind)
                SHK_RIGHT: r = a >> amt;
                SHK_ARITH: r = W'($signed(a) >>> amt);
                default:   r = a << amt;
            endcase
        end

        // Zero-extend the lane result to the register width
        always_comb lane_out[g] = XLEN'(r);
    end

    // Pick the lane that matches the operation class
    always_comb shifted = is_full ? lane_out[0] : lane_out[1];

endmodule

// File: rtl/pfvm_alu_movext.sv
// Module: move with optional sign extension.
// Does: offset 0 copies the operand; offset 8<<k sign-extends the low 8<<k bits.
//       The widest tap is legal only in the full-width class.
// Assumes: 8 << (EXT_TAPS-1) < XLEN.
module pfvm_alu_movext
    import pfvm_alu_pkg::*;
#(
    parameter int XLEN = 64,
    parameter int OFFW = 16
) (
    input  logic            is_full,
    input  logic [OFFW-1:0] offset,
    input  logic [XLEN-1:0] operand,
    output logic [XLEN-1:0] moved,
    output logic            ok
);
    logic [XLEN-1:0]     tap_val [EXT_TAPS];
    logic [EXT_TAPS-1:0] tap_hit;
    logic [EXT_TAPS-1:0] tap_ok;

    // One tap per source width
    for (genvar k = 0; k < EXT_TAPS; k++) begin : g_tap
        localparam int EW = 8 << k;
        localparam logic [OFFW-1:0] TAP_OFF = OFFW'(EW);

        // Sign-extend the low EW operand bits
        always_comb tap_val[k] = XLEN'($signed(operand[EW-1:0]));

        // Match this tap's offset; the widest tap needs the full class
        always_comb begin
            tap_hit[k] = (offset == TAP_OFF);
            tap_ok[k]  = (k < EXT_TAPS - 1) ? 1'b1 : is_full;
        end
    end

    // Select the plain copy or the matching tap and report legality
    always_comb begin
        moved = operand;
        ok    = (offset == '0);
        for (int k = 0; k < EXT_TAPS; k++) begin
            if (tap_hit[k]) begin
                moved = tap_val[k];
                ok    = tap_ok[k];
            end
        end
    end

endmodule

// File: rtl/pfvm_alu_exec.sv
// Module: packet-filter VM ALU execute unit (top).
// Does: selects the operand, runs arithmetic, bitwise, shift or move, clears
//       the upper half for the 32-bit class and registers the result. Illegal
//       encodings return the destination unchanged and raise a flag.
// Assumes: divide, modulo and byte swap go to other units; their codes are flagged.
module pfvm_alu_exec
    import pfvm_alu_pkg::*;
#(
    parameter int XLEN = 64,
    parameter int IMMW = 32,
    parameter int OFFW = 16,
    parameter int OPW  = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            issue_valid,
    input  logic            is_64,
    input  logic [OPW-1:0]  op_code,
    input  logic            use_reg,
    input  logic [OFFW-1:0] offset,
    input  logic [XLEN-1:0] dst_val,
    input  logic [XLEN-1:0] src_reg,
    input  logic [IMMW-1:0] imm,
    output logic            res_valid,
    output logic [XLEN-1:0] result,
    output logic            illegal
);
    localparam int HALF = XLEN / 2;
    localparam int SHW  = $clog2(XLEN);

    exec_ctl_t       ctl;
    logic [XLEN-1:0] operand;
    logic [XLEN-1:0] logic_res;
    logic [XLEN-1:0] shift_res;
    logic [XLEN-1:0] move_res;
    logic            move_ok;
    logic [XLEN-1:0] raw_res;
    logic [XLEN-1:0] class_res;
    logic            legal;
    logic [XLEN-1:0] next_res;

    logic            valid_q;
    logic [XLEN-1:0] result_q;
    logic            illegal_q;

    // Decode the op code into path, shift kind and offset rule
    always_comb ctl = decode_op(op_code);

    pfvm_alu_operand #(.XLEN(XLEN), .IMMW(IMMW)) u_operand (
        .use_reg (use_reg),
        .src_reg (src_reg),
        .imm     (imm),
        .operand (operand)
    );

    pfvm_alu_shift #(.XLEN(XLEN)) u_shift (
        .is_full (is_64),
        .kind    (ctl.kind),
        .value   (dst_val),
        .count   (operand[SHW-1:0]),
        .shifted (shift_res)
    );

    pfvm_alu_movext #(.XLEN(XLEN), .OFFW(OFFW)) u_movext (
        .is_full (is_64),
        .offset  (offset),
        .operand (operand),
        .moved   (move_res),
        .ok      (move_ok)
    );

    // Full-width add, subtract and bitwise; the low half is the 32-bit answer
    always_comb begin
        unique case (op_code)
            OPC_SUB: logic_res = dst_val - operand;
            OPC_OR:  logic_res = dst_val | operand;
            OPC_AND: logic_res = dst_val & operand;
            OPC_XOR: logic_res = dst_val ^ operand;
            default: logic_res = dst_val + operand;
        endcase
    end

    // Route the path's output
    always_comb begin
        unique case (ctl.path)
            PATH_SHIFT: raw_res = shift_res;
            PATH_MOVE:  raw_res = move_res;
            default:    raw_res = logic_res;
        endcase
    end

    // Clear the upper half for the 32-bit class
    always_comb class_res = is_64 ? raw_res : XLEN'(raw_res[HALF-1:0]);

    // Legal when the op exists here and its offset rule is met
    always_comb begin
        unique case (ctl.path)
            PATH_NONE: legal = 1'b0;
            PATH_MOVE: legal = move_ok;
            default:   legal = (offset == '0) || !ctl.zero_off_needed;
        endcase
    end

    // Keep the destination when the encoding is rejected
    always_comb next_res = legal ? class_res : dst_val;

    // Result register with synchronous active-low reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q   <= 1'b0;
            result_q  <= '0;
            illegal_q <= 1'b0;
        end else begin
            valid_q <= issue_valid;
            if (issue_valid) begin
                result_q  <= next_res;
                illegal_q <= !legal;
            end else begin
                illegal_q <= 1'b0;
            end
        end
    end

    always_comb begin
        res_valid = valid_q;
        result    = result_q;
        illegal   = illegal_q;
    end

    // R1: one-cycle latency and a flag qualified by the valid strobe
    assert_issue_to_valid_R1: assert property (@(posedge clk) disable iff (!rst_n)
        issue_valid |=> res_valid);
    assert_idle_to_invalid_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !issue_valid |=> !res_valid);
    assert_flag_qualified_R1: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |-> res_valid);

    // R11: a rejected encoding returns the destination it was given
    assert_reject_keeps_dst_R11: assert property (@(posedge clk) disable iff (!rst_n)
        issue_valid |=> (!illegal || result == $past(dst_val)));

    // R11: an accepted non-move operation had a zero offset
    assert_offset_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
        issue_valid && op_code != OPC_MOV && offset != '0 |=> illegal);

    // R10: accepted 32-bit class results have a clear upper half
    assert_upper_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
        issue_valid && !is_64 |=> (illegal || result[XLEN-1:HALF] == '0));

    // R9: 32-bit sign extension of a 32-bit source is rejected
    assert_movsx32_wide_R9: assert property (@(posedge clk) disable iff (!rst_n)
        issue_valid && !is_64 && op_code == OPC_MOV && offset == OFFW'(32) |=> illegal);

    // R6: arithmetic right shift keeps the sign bit of its width
    assert_arsh_sign64_R6: assert property (@(posedge clk) disable iff (!rst_n)
        issue_valid && is_64 && op_code == OPC_ARSH && offset == '0
        |=> result[XLEN-1] == $past(dst_val[XLEN-1]));
    assert_arsh_sign32_R6: assert property (@(posedge clk) disable iff (!rst_n)
        issue_valid && !is_64 && op_code == OPC_ARSH && offset == '0
        |=> result[HALF-1] == $past(dst_val[HALF-1]));

endmodule

// File: tb/sim_pfvm_alu_exec.sv
`timescale 1ns/1ps
module sim_pfvm_alu_exec;

    typedef struct packed {
        logic        is64;
        logic [3:0]  op;
        logic        ureg;
        logic [15:0] off;
        logic [63:0] dst;
        logic [63:0] src;
        logic [31:0] imm;
        logic [63:0] exp;
        logic        bad;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 30;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 4'h0, 1'b1, 16'd0, 64'hFFFF_FFFF_FFFF_FFFF, 64'd2, 32'd0, 64'd1, 1'b0, 4'd3},                       // R3 64 add wraps
        '{1'b0, 4'h0, 1'b1, 16'd0, 64'h0000_0001_FFFF_FFFF, 64'd1, 32'd0, 64'd0, 1'b0, 4'd3},                       // R3 32 add wraps
        '{1'b1, 4'h1, 1'b0, 16'd0, 64'd5, 64'd0, 32'd7, 64'hFFFF_FFFF_FFFF_FFFE, 1'b0, 4'd3},                        // R3 sub imm
        '{1'b1, 4'h1, 1'b1, 16'd0, 64'd0, 64'd1, 32'd0, 64'hFFFF_FFFF_FFFF_FFFF, 1'b0, 4'd3},                        // R3 64 sub wraps
        '{1'b1, 4'h0, 1'b0, 16'd0, 64'h100, 64'd0, 32'hFFFF_FFF0, 64'hF0, 1'b0, 4'd2},                               // R2 negative imm
        '{1'b0, 4'h4, 1'b0, 16'd0, 64'd0, 64'd0, 32'h8000_0000, 64'h0000_0000_8000_0000, 1'b0, 4'd2},                // R2 imm 32 class
        '{1'b1, 4'h4, 1'b0, 16'd0, 64'd0, 64'd0, 32'h8000_0000, 64'hFFFF_FFFF_8000_0000, 1'b0, 4'd2},                // R2 imm 64 class
        '{1'b1, 4'h5, 1'b1, 16'd0, 64'hF0F0_F0F0_F0F0_F0F0, 64'hFF00_FF00_FF00_FF00, 32'd0, 64'hF000_F000_F000_F000, 1'b0, 4'd4}, // R4 and
        '{1'b1, 4'ha, 1'b1, 16'd0, 64'hAAAA_AAAA_AAAA_AAAA, 64'hFFFF_FFFF_0000_0000, 32'd0, 64'h5555_5555_AAAA_AAAA, 1'b0, 4'd4}, // R4 xor
        '{1'b1, 4'h4, 1'b1, 16'd0, 64'h0F00, 64'h00F0, 32'd0, 64'h0FF0, 1'b0, 4'd4},                                // R4 or
        '{1'b1, 4'h6, 1'b1, 16'd0, 64'd1, 64'h43, 32'd0, 64'd8, 1'b0, 4'd5},                                        // R5 lsh mask 3F
        '{1'b0, 4'h6, 1'b1, 16'd0, 64'h0000_0001_0000_0001, 64'h23, 32'd0, 64'd8, 1'b0, 4'd5},                      // R5 lsh mask 1F
        '{1'b1, 4'h7, 1'b1, 16'd0, 64'h8000_0000_0000_0000, 64'd63, 32'd0, 64'd1, 1'b0, 4'd5},                      // R5 rsh 64
        '{1'b0, 4'h7, 1'b1, 16'd0, 64'hFFFF_FFFF_8000_0000, 64'h3F, 32'd0, 64'd1, 1'b0, 4'd5},                      // R5 rsh 32 masked
        '{1'b1, 4'hc, 1'b1, 16'd0, 64'h8000_0000_0000_0000, 64'd4, 32'd0, 64'hF800_0000_0000_0000, 1'b0, 4'd6},      // R6 arsh 64 neg
        '{1'b0, 4'hc, 1'b1, 16'd0, 64'h0000_0000_8000_0000, 64'd4, 32'd0, 64'h0000_0000_F800_0000, 1'b0, 4'd6},      // R6 arsh 32 neg
        '{1'b1, 4'hc, 1'b1, 16'd0, 64'h4000_0000_0000_0000, 64'd1, 32'd0, 64'h2000_0000_0000_0000, 1'b0, 4'd6},      // R6 arsh pos
        '{1'b1, 4'hb, 1'b1, 16'd0, 64'd0, 64'h1234_5678_9ABC_DEF0, 32'd0, 64'h1234_5678_9ABC_DEF0, 1'b0, 4'd7},      // R7 mov 64
        '{1'b0, 4'hb, 1'b1, 16'd0, 64'd0, 64'h1234_5678_9ABC_DEF0, 32'd0, 64'h0000_0000_9ABC_DEF0, 1'b0, 4'd7},      // R7 mov 32
        '{1'b1, 4'hb, 1'b1, 16'd8, 64'd0, 64'h1234_5678_9ABC_DE80, 32'd0, 64'hFFFF_FFFF_FFFF_FF80, 1'b0, 4'd8},      // R8 sx8
        '{1'b1, 4'hb, 1'b1, 16'd16, 64'd0, 64'h0000_0000_0000_8001, 32'd0, 64'hFFFF_FFFF_FFFF_8001, 1'b0, 4'd8},     // R8 sx16
        '{1'b1, 4'hb, 1'b1, 16'd32, 64'd0, 64'h0000_0000_8000_0000, 32'd0, 64'hFFFF_FFFF_8000_0000, 1'b0, 4'd8},     // R8 sx32
        '{1'b0, 4'hb, 1'b1, 16'd8, 64'd0, 64'h0000_0000_0000_00FF, 32'd0, 64'h0000_0000_FFFF_FFFF, 1'b0, 4'd9},      // R9 sx8
        '{1'b0, 4'hb, 1'b1, 16'd16, 64'd0, 64'h0000_0001_0000_8000, 32'd0, 64'h0000_0000_FFFF_8000, 1'b0, 4'd9},     // R9 sx16
        '{1'b0, 4'hb, 1'b1, 16'd8, 64'd0, 64'h0000_0000_0000_007F, 32'd0, 64'h7F, 1'b0, 4'd9},                       // R9 sx8 positive
        '{1'b0, 4'h1, 1'b1, 16'd0, 64'hFFFF_0000_0000_0000, 64'd1, 32'd0, 64'h0000_0000_FFFF_FFFF, 1'b0, 4'd10},     // R10 upper cleared
        '{1'b1, 4'h0, 1'b1, 16'd1, 64'hDEAD, 64'd1, 32'd0, 64'hDEAD, 1'b1, 4'd11},                                   // R11 add offset
        '{1'b1, 4'hb, 1'b1, 16'd4, 64'hBEEF, 64'd1, 32'd0, 64'hBEEF, 1'b1, 4'd11},                                   // R11 mov bad offset
        '{1'b1, 4'h2, 1'b1, 16'd0, 64'h1111, 64'd3, 32'd0, 64'h1111, 1'b1, 4'd12},                                   // R12 op 2
        '{1'b0, 4'hd, 1'b0, 16'd0, 64'hFFFF_FFFF_0000_2222, 64'd0, 32'd16, 64'hFFFF_FFFF_0000_2222, 1'b1, 4'd12}     // R12 op d
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        issue_valid = 1'b0;
    logic        is_64 = 1'b0;
    logic [3:0]  op_code = '0;
    logic        use_reg = 1'b0;
    logic [15:0] offset = '0;
    logic [63:0] dst_val = '0;
    logic [63:0] src_reg = '0;
    logic [31:0] imm = '0;
    logic        res_valid;
    logic [63:0] result;
    logic        illegal;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    pfvm_alu_exec u0 (
        .clk(clk), .rst_n(rst_n), .issue_valid(issue_valid), .is_64(is_64),
        .op_code(op_code), .use_reg(use_reg), .offset(offset), .dst_val(dst_val),
        .src_reg(src_reg), .imm(imm), .res_valid(res_valid), .result(result),
        .illegal(illegal)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic drive(input vec_t v);
        is_64   = v.is64;
        op_code = v.op;
        use_reg = v.ureg;
        offset  = v.off;
        dst_val = v.dst;
        src_reg = v.src;
        imm     = v.imm;
    endtask

    initial begin
        #(8 * 20000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        // R1: reset holds outputs at zero even with an issue pending
        issue_valid = 1'b1;
        drive(VECS[0]);
        repeat (3) @(negedge clk);
        chk("R1 reset res_valid", 64'(res_valid), 64'd0);
        chk("R1 reset result", result, 64'd0);
        chk("R1 reset illegal", 64'(illegal), 64'd0);
        rst_n = 1'b1;

        // Vector table walk
        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            drive(VECS[i]);
            issue_valid = 1'b1;
            @(negedge clk);
            chk($sformatf("R%0d vec %0d result", VECS[i].req, i), result, VECS[i].exp);
            chk($sformatf("R%0d vec %0d illegal", VECS[i].req, i), 64'(illegal), 64'(VECS[i].bad));
            chk($sformatf("R%0d vec %0d valid", VECS[i].req, i), 64'(res_valid), 64'd1);
        end

        // R9: offset 32 in the 32-bit class is rejected, destination kept
        @(negedge clk);
        is_64 = 1'b0; op_code = 4'hb; use_reg = 1'b1; offset = 16'd32;
        dst_val = 64'h0000_0000_0000_0055; src_reg = 64'h8000_0000;
        @(negedge clk);
        chk("R9 sx32 in 32 class illegal", 64'(illegal), 64'd1);
        chk("R9 sx32 in 32 class result", result, 64'h55);

        // R1: no issue gives no valid and drops the flag; result is held
        issue_valid = 1'b0;
        @(negedge clk);
        chk("R1 idle res_valid", 64'(res_valid), 64'd0);
        chk("R1 idle illegal", 64'(illegal), 64'd0);

        // R1: latency is one cycle - output changes only after the edge
        op_code = 4'h0; is_64 = 1'b1; offset = 16'd0; dst_val = 64'd10; src_reg = 64'd20;
        issue_valid = 1'b1;
        #1;
        chk("R1 before edge valid", 64'(res_valid), 64'd0);
        @(negedge clk);
        chk("R1 after edge result", result, 64'd30);

        // R1: reset mid-stream clears a raised flag
        offset = 16'd2;
        @(negedge clk);
        chk("R1 flag before reset", 64'(illegal), 64'd1);
        rst_n = 1'b0;
        @(negedge clk);
        chk("R1 flag after reset", 64'(illegal), 64'd0);
        chk("R1 result after reset", result, 64'd0);
        rst_n = 1'b1;
        issue_valid = 1'b0;

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule